// File: doc/BRIEF.md
# ADC Code Histogram Linearity Analyzer

The analyzer sits on the output of an analog-to-digital converter under test while a slow linear triangle ramp sweeps the converter input, typically for 100 to 150 ramp periods. Every valid output code captured between a start pulse and a stop pulse is tallied in a per-code hit counter. Offset, gain and non-linearity faults show up as uneven tallies.

After stop, a post-processing pass sums the interior code counts and normalises each code against the average. It does this with one serial division per code and stores a signed fixed-point differential linearity error (DLE) for every code, plus a running integral linearity error (ILE). The two end codes also soak up out-of-range samples, so they are left out of the average and report zero DLE. A readout port indexed by code returns the raw count, the DLE and the ILE in the same cycle. A done flag marks the point where the results are complete.

With the default parameters the converter width is 8 bits (256 bins), the counters are 16 bits and the results are Q8.8.

Top module: `adc_linearity_analyzer`

## Requirements
- R1: A one-cycle `start_i` pulse, accepted in any state, clears every bin count, every DLE and ILE result, `done_o` and `ovf_o`, and begins a capture. When `start_i` and `stop_i` are high in the same cycle, start wins and capture continues.
- R2: During a capture, each cycle with `code_valid_i` high adds one to the count of code `code_i`, and `rd_count_o` returns the count of code `rd_code_i` combinationally.
- R3: A bin count stops at 2^CNT_W-1 instead of wrapping. A hit on a full bin sets `ovf_o`, which stays high until the next start.
- R4: After stop, let T be the sum of the counts of codes 1 to N-2. For each interior code k, DLE = floor(count_k * (N-2) * 2^FRAC_W / T) - 2^FRAC_W. It is given in two's complement with FRAC_W fraction bits (Q8.8 by default) and clamped to the signed OUT_W range.
- R5: Codes 0 and N-1 always report DLE 0, and their counts do not enter T.
- R6: The ILE of code k is the clamped running sum of the DLE of codes 1 to k. The ILE of code 0 is 0, and the ILE of code N-1 equals that of code N-2.
- R7: If T is zero, every DLE and ILE reads 0.
- R8: `done_o` rises once every code has been processed and stays high until the next start.
- R9: Valid samples outside a capture have no effect on any count. These cover samples before the first start, after stop, and during processing. A `stop_i` pulse outside a capture is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear all state and begin capture |
| stop_i | input | 1 | End capture and begin processing |
| code_valid_i | input | 1 | Sample strobe for `code_i` |
| code_i | input | CODE_W | Converter output code |
| rd_code_i | input | CODE_W | Code selected for readout |
| rd_count_o | output | CNT_W | Hit count of the selected code |
| rd_dle_o | output | OUT_W | Signed DLE of the selected code |
| rd_ile_o | output | OUT_W | Signed ILE of the selected code |
| done_o | output | 1 | Results complete |
| ovf_o | output | 1 | Sticky bin saturation flag |

## Verification
The assertions check the following on every cycle:
- counter saturation sets the sticky overflow flag, and the flag holds;
- the bins are empty right after start;
- each serial division satisfies quotient times divisor plus remainder equals dividend;
- no division is launched with a zero total;
- the end codes are written with zero DLE;
- done behaves correctly around start.

The arithmetic of the DLE and ILE values, the exclusion of out-of-window samples and the start-over-stop priority can only be seen through the bench's scenarios. These scenarios are uniform ramps, weighted code distributions, a saturating burst and an edge-only capture, each compared against values computed from the formulas.

// File: rtl/adc_lin_pkg.sv
package adc_lin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SUM,
    ST_DIV,
    ST_DONE
  } lin_state_e;
endpackage

// File: rtl/hist_bin_array.sv
module hist_bin_array #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic [CODE_W-1:0] inc_code_i,
  input  logic [CODE_W-1:0] rd_a_code_i,
  output logic [CNT_W-1:0]  rd_a_cnt_o,
  input  logic [CODE_W-1:0] rd_b_code_i,
  output logic [CNT_W-1:0]  rd_b_cnt_o,
  output logic              ovf_o
);
  localparam int N = 2 ** CODE_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] bins_q [N];
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) bins_q[i] <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      for (int i = 0; i < N; i++) bins_q[i] <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      if (bins_q[inc_code_i] == CMAX) ovf_q <= 1'b1;
      else bins_q[inc_code_i] <= bins_q[inc_code_i] + 1'b1;
    end
  end

  assign rd_a_cnt_o = bins_q[rd_a_code_i];
  assign rd_b_cnt_o = bins_q[rd_b_code_i];
  assign ovf_o      = ovf_q;

  AST_SAT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clear_i && bins_q[inc_code_i] == CMAX |=> ovf_o); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clear_i |=> ovf_o); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> rd_b_cnt_o == '0 && !ovf_o); // R1
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CW = $clog2(NUM_W + 1);
  localparam int PW = NUM_W + DEN_W;

  logic [NUM_W-1:0] dvd_q, num_q;
  logic [DEN_W-1:0] den_q, rem_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {rem_q, dvd_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go_i) begin
      dvd_q  <= num_i;
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      cnt_q  <= CW'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      dvd_q <= {dvd_q[NUM_W-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = dvd_q;

  logic [PW-1:0] recon;
  assign recon = PW'(dvd_q) * PW'(den_q) + PW'(rem_q);

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> recon == PW'(num_q) && rem_q < den_q); // R4
  AST_DEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> den_i != '0); // R7
endmodule

// File: rtl/lin_result_store.sv
module lin_result_store #(
  parameter int CODE_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    wr_i,
  input  logic [CODE_W-1:0]       wr_idx_i,
  input  logic signed [OUT_W-1:0] wr_dle_i,
  input  logic signed [OUT_W-1:0] wr_ile_i,
  input  logic [CODE_W-1:0]       rd_idx_i,
  output logic signed [OUT_W-1:0] rd_dle_o,
  output logic signed [OUT_W-1:0] rd_ile_o
);
  localparam int N = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] LAST = CODE_W'(N - 1);

  logic signed [OUT_W-1:0] dle_q [N];
  logic signed [OUT_W-1:0] ile_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        dle_q[i] <= '0;
        ile_q[i] <= '0;
      end
    end else if (clear_i) begin
      for (int i = 0; i < N; i++) begin
        dle_q[i] <= '0;
        ile_q[i] <= '0;
      end
    end else if (wr_i) begin
      dle_q[wr_idx_i] <= wr_dle_i;
      ile_q[wr_idx_i] <= wr_ile_i;
    end
  end

  assign rd_dle_o = dle_q[rd_idx_i];
  assign rd_ile_o = ile_q[rd_idx_i];

  AST_EDGE_DLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wr_idx_i == '0 || wr_idx_i == LAST) |-> wr_dle_i == '0); // R5
endmodule

// File: rtl/adc_linearity_analyzer.sv
module adc_linearity_analyzer
  import adc_lin_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    code_valid_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic [CODE_W-1:0]       rd_code_i,
  output logic [CNT_W-1:0]        rd_count_o,
  output logic signed [OUT_W-1:0] rd_dle_o,
  output logic signed [OUT_W-1:0] rd_ile_o,
  output logic                    done_o,
  output logic                    ovf_o
);
  localparam int N     = 2 ** CODE_W;
  localparam int INNER = N - 2;
  localparam int TOT_W = CNT_W + CODE_W;
  localparam int NUM_W = TOT_W + FRAC_W;
  localparam int WW    = NUM_W + 2;
  localparam logic [CODE_W-1:0] LAST   = CODE_W'(N - 1);
  localparam logic [CODE_W-1:0] PENULT = CODE_W'(N - 2);
  localparam logic signed [WW-1:0] ONE_W = WW'(64'sd1 <<< FRAC_W);
  localparam logic signed [WW-1:0] WMAX  = WW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [WW-1:0] WMIN  = -WMAX - WW'(1);

  lin_state_e              state_q;
  logic [CODE_W-1:0]       idx_q;
  logic [TOT_W-1:0]        total_q;
  logic signed [OUT_W-1:0] ile_q;
  logic                    pend_q;

  logic [CNT_W-1:0]        bin_cnt;
  logic                    div_go, div_done;
  logic [NUM_W-1:0]        div_num, div_quo;
  logic                    res_wr;
  logic signed [OUT_W-1:0] res_dle, res_ile;
  logic signed [WW-1:0]    dle_wide, ile_wide;
  logic signed [OUT_W-1:0] dle_sat, ile_sat;

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [WW-1:0] v);
    if (v > WMAX) return WMAX[OUT_W-1:0];
    if (v < WMIN) return WMIN[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  hist_bin_array #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_i),
    .inc_i       (state_q == ST_CAPT && code_valid_i),
    .inc_code_i  (code_i),
    .rd_a_code_i (idx_q),
    .rd_a_cnt_o  (bin_cnt),
    .rd_b_code_i (rd_code_i),
    .rd_b_cnt_o  (rd_count_o),
    .ovf_o       (ovf_o)
  );

  // dividend = count * (N-2) * 2^FRAC, divisor = interior total
  assign div_num = (NUM_W'(bin_cnt) * NUM_W'(INNER)) << FRAC_W;

  seq_divider #(.NUM_W(NUM_W), .DEN_W(TOT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (total_q),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  assign dle_wide = $signed({2'b00, div_quo}) - ONE_W;
  assign dle_sat  = clamp(dle_wide);
  assign ile_wide = WW'(ile_q) + WW'(dle_sat);
  assign ile_sat  = clamp(ile_wide);

  always_comb begin
    div_go  = 1'b0;
    res_wr  = 1'b0;
    res_dle = '0;
    res_ile = ile_q;
    if (state_q == ST_DIV && !start_i) begin
      if (idx_q == LAST || total_q == '0) begin
        res_wr = 1'b1;
      end else if (!pend_q) begin
        div_go = 1'b1;
      end else if (div_done) begin
        res_wr  = 1'b1;
        res_dle = dle_sat;
        res_ile = ile_sat;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      ile_q   <= '0;
      pend_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_CAPT;
      idx_q   <= '0;
      total_q <= '0;
      ile_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CAPT: if (stop_i) begin
          state_q <= ST_SUM;
          idx_q   <= CODE_W'(1);
          total_q <= '0;
        end
        ST_SUM: begin
          total_q <= total_q + TOT_W'(bin_cnt);
          if (idx_q == PENULT) begin
            state_q <= ST_DIV;
            idx_q   <= CODE_W'(1);
            ile_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DIV: begin
          if (div_go) pend_q <= 1'b1;
          if (res_wr) begin
            pend_q <= 1'b0;
            ile_q  <= res_ile;
            if (idx_q == LAST) state_q <= ST_DONE;
            else idx_q <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  lin_result_store #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .wr_i     (res_wr),
    .wr_idx_i (idx_q),
    .wr_dle_i (res_dle),
    .wr_ile_i (res_ile),
    .rd_idx_i (rd_code_i),
    .rd_dle_o (rd_dle_o),
    .rd_ile_o (rd_ile_o)
  );

  assign done_o = (state_q == ST_DONE);

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o); // R1
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R8
  AST_ZERO_TOTAL_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr && total_q == '0 |-> res_dle == '0 && res_ile == '0); // R7
endmodule

// File: tb/tb_adc_linearity_analyzer.sv
module tb_adc_linearity_analyzer;
  localparam int CW = 4;
  localparam int NW = 8;
  localparam int FW = 8;
  localparam int OW = 16;
  localparam int N  = 2 ** CW;
  localparam longint CMAX = (1 << NW) - 1;
  localparam longint SMAX = (1 << (OW - 1)) - 1;
  localparam longint SMIN = -(1 << (OW - 1));

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, stop = 1'b0, cvalid = 1'b0;
  logic [CW-1:0] code = '0, rd_code = '0;
  logic [NW-1:0] rd_count;
  logic signed [OW-1:0] rd_dle, rd_ile;
  logic done, ovf;

  adc_linearity_analyzer #(.CODE_W(CW), .CNT_W(NW), .FRAC_W(FW), .OUT_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .code_valid_i(cvalid), .code_i(code), .rd_code_i(rd_code),
    .rd_count_o(rd_count), .rd_dle_o(rd_dle), .rd_ile_o(rd_ile),
    .done_o(done), .ovf_o(ovf)
  );

  int n_chk = 0, n_fail = 0;
  longint exp_cnt [N];
  bit capt = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampv(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic send(int c);
    cvalid = 1'b1;
    code = CW'(c);
    if (capt && exp_cnt[c] < CMAX) exp_cnt[c]++;
    @(negedge clk);
    cvalid = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    capt = 1'b1;
    for (int k = 0; k < N; k++) exp_cnt[k] = 0;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    capt = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R8 done rises"}, done, 1);
  endtask

  task automatic check_all(string tag);
    longint t = 0, ile = 0, dle, q;
    for (int k = 1; k < N - 1; k++) t += exp_cnt[k];
    for (int k = 0; k < N; k++) begin
      dle = 0;
      if (k > 0 && k < N - 1 && t != 0) begin
        q = (exp_cnt[k] * (N - 2) * (1 << FW)) / t;
        dle = clampv(q - (1 << FW));
        ile = clampv(ile + dle);
      end
      rd_code = CW'(k);
      #1;
      chk({tag, " R2 count"}, rd_count, exp_cnt[k]);
      chk({tag, (k == 0 || k == N - 1) ? " R5 edge dle" : " R4 dle"}, rd_dle, dle);
      chk({tag, " R6 ile"}, rd_ile, ile);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_code = 3;
    #1;
    chk("R1 reset done", done, 0);
    chk("R1 reset ovf", ovf, 0);
    chk("R1 reset count", rd_count, 0);

    // R9: samples and stop before any start are ignored
    repeat (4) send(5);
    do_stop();
    rd_code = 5;
    #1;
    chk("R9 pre-start count", rd_count, 0);

    // uniform triangle ramp: interior codes equal
    do_start();
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < N; k++) send(k);
      for (int k = N - 2; k > 0; k--) send(k);
    end
    do_stop();
    repeat (5) send(7);   // R9 samples during processing ignored
    wait_done("uniform");
    repeat (3) send(7);   // R9 samples after done ignored
    check_all("uniform R4");
    repeat (10) @(negedge clk);
    chk("R8 done holds", done, 1);

    // start and stop together: start wins, capture continues (R1)
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    capt = 1'b1;
    for (int k = 0; k < N; k++) exp_cnt[k] = 0;
    chk("R1 done cleared by start", done, 0);
    rd_code = 7;
    #1;
    chk("R1 bins cleared by start", rd_count, 0);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < N; k++)
        repeat ((k * 7) % 5 + 1) send(k);
    do_stop();
    wait_done("weighted");
    check_all("weighted R4 R6");

    // saturating burst
    do_start();
    repeat (300) send(5);
    repeat (3) send(9);
    send(0);
    do_stop();
    chk("R3 ovf set", ovf, 1);
    rd_code = 5;
    #1;
    chk("R3 saturated count", rd_count, CMAX);
    wait_done("saturate");
    check_all("saturate R3");
    chk("R3 ovf sticky", ovf, 1);

    // only edge codes: zero interior total
    do_start();
    chk("R3 ovf cleared by start", ovf, 0);
    repeat (7) send(0);
    repeat (5) send(N - 1);
    do_stop();
    wait_done("edges");
    check_all("edges R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule